// File: doc/BRIEF.md
# DDR Bank State Tracker

This block watches the command bus that a memory controller drives towards a DDR SDRAM and follows, edge by edge, what each of the four banks is doing. On every rising clock edge it decodes the chip-select, the three strobe lines, the bank address and the A10 address bit into one command. It then moves the addressed bank (or every bank, for the all-bank forms) through its life cycle: idle, opening a row, row open, waiting out an auto-precharge, closing and refreshing.

Every command is checked against the addressed bank's state and against the minimum spacings, which are given as clock-cycle counts. A command that breaks a rule is not applied to the tracked state. Instead, the block raises a one-cycle flag with a 3-bit code that says which rule was broken. It is meant to sit beside a controller as a protocol checker, or to be used inside one as the source of truth for which banks can take a command.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank reads IDLE, every ready bit is 1, and `illegal` and `reason` are 0.
- R2: With `cs_n` low, {ras_n,cas_n,we_n} decodes as follows: 011 ACT, 101 READ, 100 WRITE, 010 PRE, 001 REFA, 000 MRS, 110 TERM, 111 NOP. With `cs_n` high the bus carries no command. Bank state codes are IDLE 0, OPENING 1, OPEN 2, RD_AP 3, WR_AP 4, CLOSING 5, REFRESH 6. An accepted ACT at cycle n moves the bank to OPENING, and the bank reads OPEN from cycle n+T_RCD. A ready bit is 1 exactly when its bank is IDLE or OPEN.
- R3: READ and WRITE are accepted only by an OPEN bank. To an OPENING bank they give reason 2. To a bank in any other state they give reason 1. Without A10 they leave the bank OPEN.
- R4: PRE to an OPEN bank whose last ACT was fewer than T_RAS cycles earlier, or to an OPENING bank, gives reason 7. An accepted PRE at cycle n moves an OPEN bank to CLOSING, and the bank reads IDLE from cycle n+T_RP. PRE to an IDLE or CLOSING bank is legal and changes nothing.
- R5: ACT to a bank in CLOSING, RD_AP or WR_AP gives reason 3. ACT to an OPENING, OPEN or REFRESH bank gives reason 1.
- R6: An ACT fewer than T_RRD cycles after the last accepted ACT gives reason 4, provided the bank itself would accept it.
- R7: An ACT fewer than T_RC cycles after the accepted ACT before the most recent one gives reason 5. This check ranks below R6.
- R8: READ with A10 at cycle n puts the bank in RD_AP. The bank reads CLOSING from cycle n+BURST_LEN/2 and IDLE from n+BURST_LEN/2+T_RP. Any PRE, READ or WRITE to the bank in RD_AP gives reason 1.
- R9: WRITE with A10 at cycle n puts the bank in WR_AP until cycle n+BURST_LEN/2+T_DAL, when it reads IDLE. READ, WRITE or PRE to the bank in that window give reason 1, and ACT gives reason 3.
- R10: PRE with A10 applies to all banks. If any bank would reject it, the code of the lowest-numbered rejecting bank is reported and no bank changes state.
- R11: REFA and MRS give reason 6 unless every bank is IDLE. An accepted REFA at cycle n puts all banks in REFRESH until cycle n+T_RFC. Commands sent to a bank in REFRESH are rejected.
- R12: TERM is legal only within BURST_LEN/2 cycles after an accepted READ without A10, with no WRITE, PRE or TERM accepted in between. Otherwise it gives reason 1.
- R13: `illegal` is high, and `reason` holds the code, in the single cycle after the rejected command; both are 0 after any accepted command. Reason codes: 1 wrong state, 2 tRCD, 3 tRP/auto-precharge, 4 tRRD, 5 two-ACT window, 6 not all idle, 7 tRAS. A rejected command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the command bus is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank qualifier |
| bank_state | output | 3*NBANK (12) | State code of bank b in bits [3b+2:3b] |
| bank_ready | output | NBANK (4) | Bank b is IDLE or OPEN |
| illegal | output | 1 | Pulse: the previous command was rejected |
| reason | output | 3 | Code of the broken rule, 0 when none |

## Verification
The bench sets BURST_LEN to 4, which gives a two-cycle auto-precharge delay. That is long enough for a read with auto-precharge to show RD_AP before it changes to CLOSING, and for a PRE to land inside that gap. It shortens T_RFC to 8 so that the whole refresh interval, including its last REFRESH cycle and the first IDLE cycle, fits in a short run. The default T_RRD of 2 and T_RC of 9 let three ACTs land inside one window within a few cycles, so that window check is reached. It also lets the bench show that the spacing check ranks above the window check. The default T_RAS of 6 lets an early and a late PRE be placed on either side of the limit.

// File: rtl/ddrbt_pkg.sv
package ddrbt_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL, CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE,
        CMD_PRE, CMD_REFA, CMD_MRS, CMD_TERM
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_RD_AP   = 3'd3,
        BK_WR_AP   = 3'd4,
        BK_CLOSING = 3'd5,
        BK_REFRESH = 3'd6
    } bank_st_e;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_STATE   = 3'd1,
        RSN_TRCD    = 3'd2,
        RSN_TRP     = 3'd3,
        RSN_TRRD    = 3'd4,
        RSN_TRC_WIN = 3'd5,
        RSN_BUSY    = 3'd6,
        RSN_TRAS    = 3'd7
    } reason_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddrbt_decode.sv
module ddrbt_decode
    import ddrbt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REFA;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_TERM;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrbt_act_window.sv
module ddrbt_act_window
    import ddrbt_pkg::*;
#(
    parameter int T_RRD = 2,
    parameter int T_RC  = 9,
    parameter int AW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_ok,
    output logic rrd_bad,
    output logic rc_bad
);
    localparam logic [AW-1:0] RRD_L = AW'(T_RRD);
    localparam logic [AW-1:0] RC_L  = AW'(T_RC);

    typedef struct packed {
        logic [AW-1:0] a0;   // cycles since the latest accepted ACT
        logic [AW-1:0] a1;   // cycles since the one before it
    } win_t;

    win_t win_q, win_d;

    function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] v);
        return (v >= RC_L) ? RC_L : v + 1'b1;
    endfunction

    always_comb begin
        win_d = win_q;
        if (act_ok) begin
            win_d.a0 = AW'(1);
            win_d.a1 = sat_inc(win_q.a0);
        end else begin
            win_d.a0 = sat_inc(win_q.a0);
            win_d.a1 = sat_inc(win_q.a1);
        end
    end

    assign rrd_bad = (win_q.a0 < RRD_L);
    assign rc_bad  = (win_q.a1 < RC_L);

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '{a0: RC_L, a1: RC_L};
        else        win_q <= win_d;
    end

    AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |-> (win_q.a0 >= RRD_L));  // R6
    AST_TWO_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |-> (win_q.a1 >= RC_L));   // R7
endmodule

// File: rtl/ddrbt_bank.sv
module ddrbt_bank
    import ddrbt_pkg::*;
#(
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RAS   = 6,
    parameter int T_RFC   = 10,
    parameter int T_DAL   = 5,
    parameter int HALF_BL = 4,
    parameter int CW      = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     cmd,
    input  logic     hit,
    input  logic     ap,
    input  logic     accept,
    output reason_e  err,
    output bank_st_e state,
    output logic     idle
);
    localparam logic [CW-1:0] RAS_L  = CW'(T_RAS);
    localparam logic [CW-1:0] RP_L   = CW'(T_RP);
    localparam logic [CW-1:0] RCD_N  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RP_N   = CW'(T_RP - 1);
    localparam logic [CW-1:0] RFC_N  = CW'(T_RFC - 1);
    localparam logic [CW-1:0] RDAP_N = CW'(HALF_BL + T_RP - 1);
    localparam logic [CW-1:0] WRAP_N = CW'(HALF_BL + T_DAL - 1);
    localparam bank_st_e RD_ENTRY = (HALF_BL > 1) ? BK_RD_AP : BK_CLOSING;

    typedef struct packed {
        bank_st_e      st;
        logic [CW-1:0] cnt;   // cycles left in a timed state
        logic [CW-1:0] ras;   // cycles since ACT, saturating at T_RAS
    } bank_reg_t;

    bank_reg_t cur_q, nxt_d;

    // rule check for the command on the bus
    always_comb begin
        err = RSN_NONE;
        if (hit) begin
            case (cmd)
                CMD_ACT: begin
                    case (cur_q.st)
                        BK_IDLE:                         err = RSN_NONE;
                        BK_RD_AP, BK_WR_AP, BK_CLOSING:  err = RSN_TRP;
                        default:                         err = RSN_STATE;
                    endcase
                end
                CMD_READ, CMD_WRITE: begin
                    case (cur_q.st)
                        BK_OPEN:    err = RSN_NONE;
                        BK_OPENING: err = RSN_TRCD;
                        default:    err = RSN_STATE;
                    endcase
                end
                CMD_PRE: begin
                    case (cur_q.st)
                        BK_IDLE, BK_CLOSING: err = RSN_NONE;
                        BK_OPEN:    err = (cur_q.ras >= RAS_L) ? RSN_NONE : RSN_TRAS;
                        BK_OPENING: err = RSN_TRAS;
                        default:    err = RSN_STATE;
                    endcase
                end
                default: err = RSN_NONE;
            endcase
        end
    end

    // next state: timers first, then the accepted command
    always_comb begin
        nxt_d = cur_q;
        if (cur_q.ras < RAS_L) nxt_d.ras = cur_q.ras + 1'b1;
        if (cur_q.cnt != '0)   nxt_d.cnt = cur_q.cnt - 1'b1;
        case (cur_q.st)
            BK_OPENING: if (cur_q.cnt == CW'(1)) nxt_d.st = BK_OPEN;
            BK_RD_AP:   if (cur_q.cnt == RP_L + 1'b1) nxt_d.st = BK_CLOSING;
            BK_WR_AP, BK_CLOSING, BK_REFRESH:
                        if (cur_q.cnt == CW'(1)) nxt_d.st = BK_IDLE;
            default: ;
        endcase
        if (accept) begin
            case (cmd)
                CMD_ACT: if (hit) begin
                    nxt_d.st  = BK_OPENING;
                    nxt_d.cnt = RCD_N;
                    nxt_d.ras = CW'(1);
                end
                CMD_READ: if (hit && ap) begin
                    nxt_d.st  = RD_ENTRY;
                    nxt_d.cnt = RDAP_N;
                end
                CMD_WRITE: if (hit && ap) begin
                    nxt_d.st  = BK_WR_AP;
                    nxt_d.cnt = WRAP_N;
                end
                CMD_PRE: if (hit && cur_q.st == BK_OPEN) begin
                    nxt_d.st  = BK_CLOSING;
                    nxt_d.cnt = RP_N;
                end
                CMD_REFA: begin
                    nxt_d.st  = BK_REFRESH;
                    nxt_d.cnt = RFC_N;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: BK_IDLE, cnt: '0, ras: RAS_L};
        else        cur_q <= nxt_d;
    end

    assign state = cur_q.st;
    assign idle  = (cur_q.st == BK_IDLE);

    AST_OPEN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == BK_OPENING && $past(cur_q.st) != BK_OPENING)
            |-> $past(cur_q.st) == BK_IDLE);  // R2
    AST_COLUMN_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && (cmd == CMD_READ || cmd == CMD_WRITE))
            |-> cur_q.st == BK_OPEN);  // R3
    AST_PRE_AFTER_TRAS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && cmd == CMD_PRE && cur_q.st == BK_OPEN)
            |-> cur_q.ras >= RAS_L);  // R4
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddrbt_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 8,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 9,
    parameter int T_RFC     = 10,
    parameter int T_DAL     = 5,
    localparam int BA_W     = $clog2(NBANK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [BA_W-1:0]    ba,
    input  logic               a10,
    output logic [3*NBANK-1:0] bank_state,
    output logic [NBANK-1:0]   bank_ready,
    output logic               illegal,
    output logic [2:0]         reason
);
    localparam int HALF_BL = BURST_LEN / 2;
    localparam int CNT_MAX = max2(max2(T_RAS, T_RFC),
                                  max2(HALF_BL + T_DAL, max2(HALF_BL + T_RP, T_RCD)));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int AW      = $clog2(T_RC + 1);
    localparam int HW      = $clog2(HALF_BL + 1);

    typedef struct packed {
        logic          illegal;
        reason_e       reason;
        logic [HW-1:0] rd_left;   // cycles of a plain read burst left
    } top_reg_t;

    top_reg_t   top_q, top_d;
    cmd_e       cmd;
    reason_e    bank_err [NBANK];
    bank_st_e   bank_st  [NBANK];
    logic [NBANK-1:0] bank_idle, bank_hit;
    logic       accept, rrd_bad, rc_bad, act_ok;
    reason_e    reason_c;

    ddrbt_decode u_decode (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
    );

    always_comb begin
        for (int b = 0; b < NBANK; b++)
            bank_hit[b] = (ba == BA_W'(b)) || (cmd == CMD_PRE && a10);
    end

    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_bank
            ddrbt_bank #(
                .T_RCD (T_RCD), .T_RP (T_RP), .T_RAS (T_RAS), .T_RFC (T_RFC),
                .T_DAL (T_DAL), .HALF_BL (HALF_BL), .CW (CW)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .cmd    (cmd),
                .hit    (bank_hit[g]),
                .ap     (a10),
                .accept (accept),
                .err    (bank_err[g]),
                .state  (bank_st[g]),
                .idle   (bank_idle[g])
            );
            assign bank_state[3*g +: 3] = bank_st[g];
            assign bank_ready[g]        = (bank_st[g] == BK_IDLE) || (bank_st[g] == BK_OPEN);

            AST_REFA_ENTERS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd == CMD_REFA && accept) |=> bank_st[g] == BK_REFRESH);  // R11
        end
    endgenerate

    assign act_ok = accept && (cmd == CMD_ACT);

    ddrbt_act_window #(.T_RRD (T_RRD), .T_RC (T_RC), .AW (AW)) u_window (
        .clk (clk), .rst_n (rst_n), .act_ok (act_ok),
        .rrd_bad (rrd_bad), .rc_bad (rc_bad)
    );

    always_comb begin
        reason_c = RSN_NONE;
        case (cmd)
            CMD_ACT: begin
                reason_c = bank_err[ba];
                if (reason_c == RSN_NONE) begin
                    if (rrd_bad)     reason_c = RSN_TRRD;
                    else if (rc_bad) reason_c = RSN_TRC_WIN;
                end
            end
            CMD_READ, CMD_WRITE: reason_c = bank_err[ba];
            CMD_PRE: begin
                if (a10) begin
                    for (int b = NBANK - 1; b >= 0; b--)
                        if (bank_err[b] != RSN_NONE) reason_c = bank_err[b];
                end else begin
                    reason_c = bank_err[ba];
                end
            end
            CMD_REFA, CMD_MRS: if (!(&bank_idle)) reason_c = RSN_BUSY;
            CMD_TERM:          if (top_q.rd_left == '0) reason_c = RSN_STATE;
            default: ;
        endcase
        accept = (cmd != CMD_DESEL) && (cmd != CMD_NOP) && (reason_c == RSN_NONE);
    end

    always_comb begin
        top_d         = top_q;
        top_d.illegal = (reason_c != RSN_NONE);
        top_d.reason  = reason_c;
        if (top_q.rd_left != '0) top_d.rd_left = top_q.rd_left - 1'b1;
        if (accept) begin
            case (cmd)
                CMD_READ:                    top_d.rd_left = a10 ? '0 : HW'(HALF_BL);
                CMD_WRITE, CMD_PRE, CMD_TERM: top_d.rd_left = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '{illegal: 1'b0, reason: RSN_NONE, rd_left: '0};
        else        top_q <= top_d;
    end

    assign illegal = top_q.illegal;
    assign reason  = top_q.reason;

    AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && !(&bank_idle)) |=> (illegal && reason == RSN_BUSY));  // R11
    AST_TERM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_TERM && accept) |-> top_q.rd_left != '0);  // R12
endmodule

// File: tb/ddr_bank_tracker_test.sv
module ddr_bank_tracker_test;
    localparam int PERIOD = 10;
    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                           C_TERM = 3'b110, C_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [11:0] bank_state;
    logic [3:0]  bank_ready;
    logic        illegal;
    logic [2:0]  reason;

    int total = 0;
    int fails = 0;

    typedef struct {
        int    rsn;
        int    bk;
        int    st;
        string tag;
    } exp_t;
    exp_t q[$];

    ddr_bank_tracker #(
        .NBANK (4), .BURST_LEN (4), .T_RCD (3), .T_RP (3), .T_RAS (6),
        .T_RRD (2), .T_RC (9), .T_RFC (8), .T_DAL (5)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .a10 (a10), .bank_state (bank_state),
        .bank_ready (bank_ready), .illegal (illegal), .reason (reason)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: one bus cycle plus the expected outcome
    task automatic send(input logic [2:0] rcw, input int bk, input logic ap,
                        input int rsn, input int cbk, input int cst, input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        {ras_n, cas_n, we_n} = rcw;
        ba  = bk[1:0];
        a10 = ap;
        q.push_back('{rsn, cbk, cst, tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(C_NOP, 0, 1'b0, 0, -1, 0, "R13");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    endtask

    // monitor: compare outputs after each edge against the queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " reason"}, int'(reason), e.rsn);
                check({e.tag, " R13 illegal"}, int'(illegal), int'(e.rsn != 0));
                if (e.bk >= 0) begin
                    check({e.tag, " state"}, int'(bank_state[3*e.bk +: 3]), e.st);
                    check({e.tag, " R2 ready"}, int'(bank_ready[e.bk]),
                          int'(e.st == 0 || e.st == 2));
                end
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        fails++;
        total++;
        $display("FAIL watchdog: got hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 states", int'(bank_state), 0);
        check("R1 ready", int'(bank_ready), 15);
        check("R1 illegal", int'(illegal), 0);
        check("R1 reason", int'(reason), 0);

        send(C_ACT,  0, 0, 0, 0, 1, "R2");   // c0
        send(C_ACT,  1, 0, 4, 1, 0, "R6");   // c1 too close
        send(C_RD,   0, 0, 2, 0, 2, "R3");   // c2 still opening
        send(C_ACT,  1, 0, 0, 1, 1, "R6");   // c3
        send(C_ACT,  2, 0, 4, 2, 0, "R6");   // c4 spacing beats window
        send(C_ACT,  2, 0, 5, 2, 0, "R7");   // c5 third in window
        send(C_PRE,  1, 0, 7, 1, 2, "R4");   // c6 before tRAS
        send(C_PRE,  0, 0, 0, 0, 5, "R4");   // c7
        send(C_RD,   0, 0, 1, 0, 5, "R3");   // c8 closing bank
        send(C_ACT,  0, 0, 3, 0, 0, "R5");   // c9 closing; idle after
        send(C_ACT,  2, 0, 0, 2, 1, "R7");   // c10 window clear
        send(C_ACT,  0, 0, 4, 0, 0, "R6");   // c11
        send(C_ACT,  0, 0, 0, 0, 1, "R7");   // c12 exactly T_RC
        send(C_TERM, 0, 0, 1, -1, 0, "R12"); // c13 no burst
        send(C_RD,   2, 0, 0, 2, 2, "R2");   // c14 plain read stays open
        send(C_TERM, 0, 0, 0, -1, 0, "R12"); // c15
        send(C_TERM, 0, 0, 1, -1, 0, "R12"); // c16 burst gone
        send(C_REF,  0, 0, 6, -1, 0, "R11"); // c17
        send(C_MRS,  0, 0, 6, -1, 0, "R11"); // c18
        send(C_PRE,  0, 1, 0, 1, 5, "R10");  // c19 all banks
        send(C_REF,  0, 0, 6, 2, 5, "R11");  // c20 still closing
        send(C_NOP,  0, 0, 0, 0, 0, "R10");  // c21
        send(C_REF,  0, 0, 0, 3, 6, "R11");  // c22
        send(C_ACT,  3, 0, 1, 3, 6, "R11");  // c23 refreshing
        idle(4);                              // c24..c27
        send(C_NOP,  0, 0, 0, 3, 6, "R11");  // c28 last refresh cycle
        send(C_NOP,  0, 0, 0, 3, 0, "R11");  // c29
        send(C_ACT,  0, 0, 0, 0, 1, "R2");   // c30
        idle(1);
        send(C_NOP,  0, 0, 0, 0, 2, "R2");   // c32
        send(C_RD,   0, 1, 0, 0, 3, "R8");   // c33 read with auto-precharge
        send(C_PRE,  0, 0, 1, 0, 5, "R8");   // c34
        send(C_NOP,  0, 0, 0, 0, 5, "R8");   // c35
        idle(1);
        send(C_ACT,  0, 0, 3, 0, 0, "R8");   // c37
        send(C_ACT,  0, 0, 0, 0, 1, "R8");   // c38
        idle(2);
        send(C_WR,   0, 1, 0, 0, 4, "R9");   // c41 write with auto-precharge
        send(C_RD,   0, 0, 1, 0, 4, "R9");   // c42
        idle(4);
        send(C_ACT,  0, 0, 3, 0, 0, "R9");   // c47
        send(C_ACT,  0, 0, 0, 0, 1, "R9");   // c48
        idle(2);
        send(C_WR,   0, 0, 0, 0, 2, "R3");   // c51
        send(C_RD,   0, 0, 0, 0, 2, "R3");   // c52
        send(C_PRE,  0, 0, 7, 0, 2, "R4");   // c53
        send(C_PRE,  3, 0, 0, 3, 0, "R4");   // c54 idle bank, no effect
        send(C_PRE,  0, 0, 0, 0, 5, "R4");   // c55
        send(C_MRS,  0, 0, 6, 0, 5, "R11");  // c56
        send(C_NOP,  0, 0, 0, 0, 0, "R4");   // c57
        send(C_MRS,  0, 0, 0, 0, 0, "R11");  // c58
        idle(2);
        @(negedge clk);
        cs_n = 1'b1;
        wait (q.size() == 0);
        #(PERIOD * 2);
        summary();
        $finish;
    end
endmodule